// File: doc/BRIEF.md
# Single-Transfer DMA Channel Arbiter

This block is the core of a small multi-channel DMA engine that moves exactly one byte or one halfword each time it owns the system bus. Each channel is set up with a source address, a destination address, a unit size, an increment choice for each address and a 16-bit count. Peripherals or software raise single-cycle request pulses. The block holds each request in a pending bit, asks the CPU side for the bus, and picks the highest-priority pending channel once the grant arrives. It performs one read from the source and one write to the destination, then gives the bus back at once. Any further unit needs a new request and a new grant.

Channel setup goes through a shared configuration port: one channel index, a write strobe and the field values. A setup whose destination is read-only memory, or whose count is zero, is refused. Such a channel gets an error flag and never makes a bus cycle. When a channel's count reaches zero it raises a terminal-count flag and a one-cycle interrupt pulse, and it disables itself.

The memory side is a valid/ready port. The block raises `mem_valid` with the address, direction, size and write data. It holds all of them unchanged until the memory side returns `mem_ready` in the same cycle. The memory side may hold `mem_ready` low for any number of cycles, and read data is taken in the cycle the read handshake completes. The configuration port must not write to a channel while that channel's transfer is in progress.

Top module: `dma_single_xfer`

## Requirements
- R1: After the write handshake of a transfer, `bus_req` is low in the following cycle. One grant carries exactly one unit.
- R2: Each request pulse on an enabled channel that is not mid-transfer causes exactly one transfer. Without a pulse no bus cycle takes place.
- R3: When several channels are pending at grant time, the lowest-numbered one is served first. Channel 0 has the highest priority.
- R4: A request pulse on the channel being transferred (from the grant cycle through its write handshake) is dropped. A lower-priority channel pending at that time is served in the next grant.
- R5: A setup with destination kind read-only memory (kind code 2'b00; 01 is RAM, 10 is peripheral, 11 is external) or a count of zero sets that channel's `err_flag` and leaves it disabled. The channel then makes no bus cycle.
- R6: A transfer is a read at the source address followed by a write at the destination address within one grant. The data read is the data written, and `mem_half` shows the unit size (1 = halfword, 0 = byte with the upper 8 bits zero).
- R7: After each transfer, each address whose increment bit is set advances by 2 for halfword or 1 for byte. An address whose increment bit is clear stays the same.
- R8: The count drops by one per transfer. When it reaches zero, `tc_flag` is set, `tc_irq` pulses for exactly one cycle and `ch_enabled` clears. Later requests on that channel cause no transfer.
- R9: While `mem_valid` is high and `mem_ready` is low, the address, direction, size and write data stay stable. The transfer still completes correctly under stalls.
- R10: After reset no flags are set, no channel is enabled and `bus_req` and `mem_valid` are low. `mem_valid` is never high without `bus_gnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Setup strobe for channel `cfg_ch` |
| cfg_ch | input | CHW | Channel being set up |
| cfg_src_addr | input | AW | Start source address |
| cfg_dst_addr | input | AW | Start destination address |
| cfg_halfword | input | 1 | Unit size: 1 halfword, 0 byte |
| cfg_src_inc | input | 1 | Advance source address after each unit |
| cfg_dst_inc | input | 1 | Advance destination address after each unit |
| cfg_dst_kind | input | 2 | Destination target kind |
| cfg_count | input | CW | Number of units |
| dreq | input | NCH | Single-cycle request pulses, one per channel |
| bus_req | output | 1 | Bus ownership request to the CPU side |
| bus_gnt | input | 1 | Bus ownership granted |
| mem_valid | output | 1 | Memory access valid |
| mem_ready | input | 1 | Memory access accepted |
| mem_we | output | 1 | 1 write, 0 read |
| mem_half | output | 1 | Access size: 1 halfword, 0 byte |
| mem_addr | output | AW | Access address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, taken on the read handshake |
| active_ch | output | CHW | Channel owning the current or last transfer |
| ch_enabled | output | NCH | Channel armed and able to transfer |
| tc_flag | output | NCH | Terminal count reached |
| tc_irq | output | NCH | One-cycle terminal-count pulse |
| err_flag | output | NCH | Setup refused |

## Verification
The bench builds the block with its defaults: four channels, 16-bit addresses and 16-bit counts. With four channels it can have two channels pending against each other while a third is mid-transfer, and it can put the highest-priority channel against the lowest. Small loaded counts bring terminal count within a few transfers, so the interrupt pulse, the self-disable and the ignored later requests are all reached. A memory model that stalls `mem_ready` every other cycle exercises the back-pressure rules, and a grant model that answers one cycle after the request exercises the wait for ownership.

// File: rtl/dma_sx_pkg.sv
package dma_sx_pkg;

  localparam int DW = 16;

  typedef enum logic [1:0] {
    TGT_ROM    = 2'b00,
    TGT_RAM    = 2'b01,
    TGT_PERIPH = 2'b10,
    TGT_EXT    = 2'b11
  } tgt_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARB,
    ST_RD,
    ST_WR
  } xfer_state_e;

  function automatic logic setup_legal(input tgt_kind_e dst_kind, input logic cnt_nonzero);
    return (dst_kind != TGT_ROM) && cnt_nonzero;
  endfunction

endpackage

// File: rtl/dma_sx_chan.sv
module dma_sx_chan
  import dma_sx_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_src,
  input  logic [AW-1:0] ld_dst,
  input  logic          ld_half,
  input  logic          ld_src_inc,
  input  logic          ld_dst_inc,
  input  logic [1:0]    ld_dst_kind,
  input  logic [CW-1:0] ld_count,
  input  logic          step,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          half,
  output logic          enabled,
  output logic          tc_flag,
  output logic          tc_irq,
  output logic          err_flag
);

  logic          src_inc_q, dst_inc_q;
  logic [CW-1:0] count_q;
  logic [AW-1:0] unit_step;
  logic          legal;

  assign unit_step = half ? AW'(2) : AW'(1);
  assign legal     = setup_legal(tgt_kind_e'(ld_dst_kind), ld_count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_addr  <= '0;
      dst_addr  <= '0;
      half      <= 1'b0;
      src_inc_q <= 1'b0;
      dst_inc_q <= 1'b0;
      count_q   <= '0;
      enabled   <= 1'b0;
      tc_flag   <= 1'b0;
      tc_irq    <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      tc_irq <= 1'b0;
      if (ld) begin
        src_addr  <= ld_src;
        dst_addr  <= ld_dst;
        half      <= ld_half;
        src_inc_q <= ld_src_inc;
        dst_inc_q <= ld_dst_inc;
        count_q   <= ld_count;
        enabled   <= legal;
        err_flag  <= !legal;
        tc_flag   <= 1'b0;
      end else if (step) begin
        if (src_inc_q) src_addr <= src_addr + unit_step;
        if (dst_inc_q) dst_addr <= dst_addr + unit_step;
        count_q <= count_q - CW'(1);
        if (count_q == CW'(1)) begin
          tc_flag <= 1'b1;
          tc_irq  <= 1'b1;
          enabled <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/dma_sx_pend.sv
module dma_sx_pend #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] dreq,
  input  logic [NCH-1:0] enabled,
  input  logic [NCH-1:0] load,
  input  logic [NCH-1:0] clr,
  input  logic [NCH-1:0] block,
  output logic [NCH-1:0] pending
);

  for (genvar i = 0; i < NCH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            pending[i] <= 1'b0;
      else if (clr[i] || load[i] || !enabled[i]) pending[i] <= 1'b0;
      else if (dreq[i] && !block[i])         pending[i] <= 1'b1;
    end
  end

endmodule

// File: rtl/dma_sx_prio.sv
module dma_sx_prio #(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] cand,
  output logic           any,
  output logic [CHW-1:0] win
);

  always_comb begin
    any = |cand;
    win = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (cand[i]) win = CHW'(i);
    end
  end

endmodule

// File: rtl/dma_single_xfer.sv
module dma_single_xfer
  import dma_sx_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [AW-1:0]  cfg_src_addr,
  input  logic [AW-1:0]  cfg_dst_addr,
  input  logic           cfg_halfword,
  input  logic           cfg_src_inc,
  input  logic           cfg_dst_inc,
  input  logic [1:0]     cfg_dst_kind,
  input  logic [CW-1:0]  cfg_count,
  input  logic [NCH-1:0] dreq,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic           mem_we,
  output logic           mem_half,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic [CHW-1:0] active_ch,
  output logic [NCH-1:0] ch_enabled,
  output logic [NCH-1:0] tc_flag,
  output logic [NCH-1:0] tc_irq,
  output logic [NCH-1:0] err_flag
);

  xfer_state_e state_q;
  logic [CHW-1:0] cur_q;
  logic [DW-1:0]  data_q;

  logic [NCH-1:0] load_v, step_v, clr_v, block_v, pend_v, cand_v, half_v;
  logic [NCH-1:0][AW-1:0] src_v, dst_v;
  logic           any_c;
  logic [CHW-1:0] win_c;
  logic           grant_now, rd_done, wr_done;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign load_v[i]  = cfg_we && (cfg_ch == CHW'(i));
    assign step_v[i]  = wr_done && (cur_q == CHW'(i));
    assign clr_v[i]   = grant_now && (win_c == CHW'(i));
    assign block_v[i] = ((state_q == ST_RD) || (state_q == ST_WR)) && (cur_q == CHW'(i));

    dma_sx_chan #(.AW(AW), .CW(CW)) chan_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld         (load_v[i]),
      .ld_src     (cfg_src_addr),
      .ld_dst     (cfg_dst_addr),
      .ld_half    (cfg_halfword),
      .ld_src_inc (cfg_src_inc),
      .ld_dst_inc (cfg_dst_inc),
      .ld_dst_kind(cfg_dst_kind),
      .ld_count   (cfg_count),
      .step       (step_v[i]),
      .src_addr   (src_v[i]),
      .dst_addr   (dst_v[i]),
      .half       (half_v[i]),
      .enabled    (ch_enabled[i]),
      .tc_flag    (tc_flag[i]),
      .tc_irq     (tc_irq[i]),
      .err_flag   (err_flag[i])
    );
  end

  dma_sx_pend #(.NCH(NCH)) pend_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .dreq   (dreq),
    .enabled(ch_enabled),
    .load   (load_v),
    .clr    (clr_v),
    .block  (block_v),
    .pending(pend_v)
  );

  assign cand_v = pend_v & ch_enabled;

  dma_sx_prio #(.NCH(NCH)) prio_i (
    .cand(cand_v),
    .any (any_c),
    .win (win_c)
  );

  assign grant_now = (state_q == ST_ARB) && bus_gnt && any_c;
  assign rd_done   = (state_q == ST_RD) && mem_ready;
  assign wr_done   = (state_q == ST_WR) && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (any_c) state_q <= ST_ARB;
        ST_ARB: begin
          if (grant_now) begin
            cur_q   <= win_c;
            state_q <= ST_RD;
          end else if (bus_gnt) begin
            state_q <= ST_IDLE;
          end
        end
        ST_RD: if (rd_done) begin
          data_q  <= half_v[cur_q] ? mem_rdata : {8'h00, mem_rdata[7:0]};
          state_q <= ST_WR;
        end
        ST_WR: if (wr_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_req   = (state_q != ST_IDLE);
  assign mem_valid = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we    = (state_q == ST_WR);
  assign mem_half  = half_v[cur_q];
  assign mem_addr  = (state_q == ST_WR) ? dst_v[cur_q] : src_v[cur_q];
  assign mem_wdata = data_q;
  assign active_ch = cur_q;

endmodule

// File: rtl/dma_single_xfer_chk.sv
module dma_single_xfer_chk #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_req,
  input logic           bus_gnt,
  input logic           mem_valid,
  input logic           mem_ready,
  input logic           mem_we,
  input logic           mem_half,
  input logic [AW-1:0]  mem_addr,
  input logic [15:0]    mem_wdata,
  input logic [CHW-1:0] active_ch,
  input logic [NCH-1:0] ch_enabled,
  input logic [NCH-1:0] tc_flag,
  input logic [NCH-1:0] tc_irq,
  input logic [NCH-1:0] err_flag
);

  assert_cycle_needs_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> bus_gnt);

  assert_hold_under_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_half) && $stable(mem_wdata)));

  assert_release_after_unit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && mem_ready) |=> !bus_req);

  assert_write_follows_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we && mem_ready) |=> (mem_valid && mem_we && $stable(active_ch)));

  assert_single_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tc_irq));

  assert_irq_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_irq) |=> !(|tc_irq));

  assert_errored_channel_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !err_flag[active_ch]);

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    assert_irq_with_tc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tc_irq[i] |-> (tc_flag[i] && !ch_enabled[i]));
    assert_err_disarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag[i] |-> !ch_enabled[i]);
  end

endmodule

bind dma_single_xfer dma_single_xfer_chk #(.NCH(NCH), .AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_half  (mem_half),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .active_ch (active_ch),
  .ch_enabled(ch_enabled),
  .tc_flag   (tc_flag),
  .tc_irq    (tc_irq),
  .err_flag  (err_flag)
);

// File: tb/dma_single_xfer_tb_top.sv
module dma_single_xfer_tb_top;

  localparam int NCH = 4;
  localparam int AW  = 16;
  localparam int CW  = 16;
  localparam int CHW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic           cfg_we = 1'b0;
  logic [CHW-1:0] cfg_ch = '0;
  logic [AW-1:0]  cfg_src_addr = '0, cfg_dst_addr = '0;
  logic           cfg_halfword = 1'b0, cfg_src_inc = 1'b0, cfg_dst_inc = 1'b0;
  logic [1:0]     cfg_dst_kind = 2'b01;
  logic [CW-1:0]  cfg_count = '0;
  logic [NCH-1:0] dreq = '0;
  logic           bus_req, bus_gnt, mem_valid, mem_ready, mem_we, mem_half;
  logic [AW-1:0]  mem_addr;
  logic [15:0]    mem_wdata, mem_rdata;
  logic [CHW-1:0] active_ch;
  logic [NCH-1:0] ch_enabled, tc_flag, tc_irq, err_flag;

  dma_single_xfer #(.NCH(NCH), .AW(AW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
    .cfg_halfword(cfg_halfword), .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc),
    .cfg_dst_kind(cfg_dst_kind), .cfg_count(cfg_count), .dreq(dreq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_half(mem_half), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .active_ch(active_ch), .ch_enabled(ch_enabled),
    .tc_flag(tc_flag), .tc_irq(tc_irq), .err_flag(err_flag)
  );

  int checks = 0;
  int fails  = 0;

  // Bus-owner and memory models
  logic stall_mode = 1'b0;
  logic [7:0] mem [256];

  function automatic logic [7:0] init_byte(input int a);
    return 8'((a * 3 + 7) & 8'hFF);
  endfunction

  initial for (int i = 0; i < 256; i++) mem[i] = init_byte(i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_gnt   <= 1'b0;
      mem_ready <= 1'b0;
    end else begin
      bus_gnt   <= bus_req;
      mem_ready <= stall_mode ? ~mem_ready : 1'b1;
    end
  end

  always_comb begin
    if (mem_half) mem_rdata = {mem[8'(mem_addr + 16'd1)], mem[mem_addr[7:0]]};
    else          mem_rdata = {8'h00, mem[mem_addr[7:0]]};
  end

  // Monitor of write handshakes, release, grant use and interrupts
  int          nwr = 0;
  int          log_ch   [64];
  int          log_addr [64];
  int          log_data [64];
  int          log_half [64];
  int          irq_cnt  [NCH];
  logic [NCH-1:0] irq_prev = '0;
  int          irq_wide = 0;
  int          r1_bad = 0;
  int          r10_bad = 0;
  logic        wr_seen = 1'b0;

  initial for (int i = 0; i < NCH; i++) irq_cnt[i] = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_seen && bus_req) r1_bad++;
      wr_seen = 1'b0;
      if (mem_valid && !bus_gnt) r10_bad++;
      if (mem_valid && mem_ready && mem_we) begin
        if (nwr < 64) begin
          log_ch[nwr]   = int'(active_ch);
          log_addr[nwr] = int'(mem_addr);
          log_data[nwr] = int'(mem_wdata);
          log_half[nwr] = int'(mem_half);
        end
        nwr++;
        mem[mem_addr[7:0]] = mem_wdata[7:0];
        if (mem_half) mem[8'(mem_addr + 16'd1)] = mem_wdata[15:8];
        wr_seen = 1'b1;
      end
      for (int i = 0; i < NCH; i++) begin
        if (tc_irq[i]) irq_cnt[i]++;
        if (tc_irq[i] && irq_prev[i]) irq_wide++;
      end
      irq_prev = tc_irq;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_ch(input int ch, input int src, input int dst, input bit half,
                         input bit sinc, input bit dinc, input int kind, input int cnt);
    @(negedge clk);
    cfg_ch       = CHW'(ch);
    cfg_src_addr = AW'(src);
    cfg_dst_addr = AW'(dst);
    cfg_halfword = half;
    cfg_src_inc  = sinc;
    cfg_dst_inc  = dinc;
    cfg_dst_kind = 2'(kind);
    cfg_count    = CW'(cnt);
    cfg_we       = 1'b1;
    @(negedge clk);
    cfg_we       = 1'b0;
  endtask

  task automatic pulse(input logic [NCH-1:0] m);
    dreq = m;
    @(negedge clk);
    dreq = '0;
  endtask

  task automatic t_reset;
    chk(bus_req == 1'b0, "R10", "bus_req after reset", int'(bus_req), 0);
    chk(mem_valid == 1'b0, "R10", "mem_valid after reset", int'(mem_valid), 0);
    chk(ch_enabled == '0 && tc_flag == '0 && err_flag == '0 && tc_irq == '0,
        "R10", "flags after reset", int'({ch_enabled, tc_flag, err_flag}), 0);
  endtask

  task automatic t_byte_increment;
    int base;
    load_ch(1, 'h10, 'h80, 1'b0, 1'b1, 1'b1, 1, 3);
    base = nwr;
    settle(20);
    chk(nwr == base, "R2", "no transfer without request", nwr - base, 0);
    @(negedge clk); pulse(4'b0010); settle(30);
    chk(nwr == base + 1, "R2", "one unit per request", nwr - base, 1);
    chk(log_addr[base] == 'h80 && log_ch[base] == 1, "R6", "first write address", log_addr[base], 'h80);
    chk(log_data[base] == int'(init_byte('h10)) && log_half[base] == 0, "R6", "byte data forwarded",
        log_data[base], int'(init_byte('h10)));
    pulse(4'b0010); settle(30);
    chk(nwr == base + 2 && log_addr[base+1] == 'h81, "R7", "destination advanced by 1",
        log_addr[base+1], 'h81);
    chk(log_data[base+1] == int'(init_byte('h11)), "R7", "source advanced by 1",
        log_data[base+1], int'(init_byte('h11)));
    chk(tc_flag[1] == 1'b0 && ch_enabled[1], "R8", "no terminal count before last unit",
        int'(tc_flag[1]), 0);
    pulse(4'b0010); settle(30);
    chk(tc_flag[1] == 1'b1 && ch_enabled[1] == 1'b0, "R8", "terminal count disarms channel",
        int'({tc_flag[1], ch_enabled[1]}), 2);
    chk(irq_cnt[1] == 1 && irq_wide == 0, "R8", "single one-cycle irq", irq_cnt[1], 1);
    pulse(4'b0010); settle(30);
    chk(nwr == base + 3, "R8", "request after terminal count ignored", nwr - base, 3);
    chk(r1_bad == 0, "R1", "bus released after each unit", r1_bad, 0);
    chk(r10_bad == 0, "R10", "access only under grant", r10_bad, 0);
  endtask

  task automatic t_halfword_stall;
    int base, e0, e1;
    stall_mode = 1'b1;
    load_ch(2, 'h20, 'hF0, 1'b1, 1'b1, 1'b0, 2, 2);
    base = nwr;
    pulse(4'b0100); settle(40);
    pulse(4'b0100); settle(40);
    e0 = {init_byte('h21), init_byte('h20)};
    e1 = {init_byte('h23), init_byte('h22)};
    chk(nwr == base + 2, "R9", "both stalled units done", nwr - base, 2);
    chk(log_data[base] == e0 && log_half[base] == 1, "R9", "halfword data under stall", log_data[base], e0);
    chk(log_data[base+1] == e1, "R7", "source advanced by 2", log_data[base+1], e1);
    chk(log_addr[base] == 'hF0 && log_addr[base+1] == 'hF0, "R7", "fixed destination",
        log_addr[base+1], 'hF0);
    chk(tc_flag[2] == 1'b1 && irq_cnt[2] == 1, "R8", "terminal count on halfword channel",
        irq_cnt[2], 1);
    stall_mode = 1'b0;
  endtask

  task automatic t_priority;
    int base;
    load_ch(3, 'h30, 'h90, 1'b0, 1'b1, 1'b1, 3, 4);
    load_ch(0, 'h40, 'hA0, 1'b0, 1'b1, 1'b1, 1, 4);
    base = nwr;
    pulse(4'b1001); settle(40);
    chk(nwr == base + 2, "R3", "both channels served", nwr - base, 2);
    chk(log_ch[base] == 0 && log_ch[base+1] == 3, "R3", "channel 0 wins",
        log_ch[base] * 16 + log_ch[base+1], 'h03);
  endtask

  task automatic t_same_channel_drop;
    int base, guard;
    load_ch(1, 'h50, 'hB0, 1'b0, 1'b1, 1'b1, 1, 5);
    base = nwr;
    pulse(4'b0010);
    guard = 0;
    while (!(mem_valid && active_ch == 2'd1) && guard < 50) begin
      @(negedge clk); guard++;
    end
    pulse(4'b1010);
    settle(50);
    chk(nwr == base + 2, "R4", "own-cycle request dropped", nwr - base, 2);
    chk(log_ch[base] == 1 && log_ch[base+1] == 3, "R4", "lower channel served next",
        log_ch[base] * 16 + log_ch[base+1], 'h13);
    chk(ch_enabled[1] == 1'b1 && tc_flag[1] == 1'b0, "R4", "channel 1 still armed",
        int'(ch_enabled[1]), 1);
  endtask

  task automatic t_illegal_setup;
    int base;
    load_ch(2, 'h60, 'hC0, 1'b0, 1'b1, 1'b1, 0, 3);
    chk(err_flag[2] == 1'b1 && ch_enabled[2] == 1'b0, "R5", "ROM destination refused",
        int'({err_flag[2], ch_enabled[2]}), 2);
    base = nwr;
    pulse(4'b0100); settle(30);
    chk(nwr == base && bus_req == 1'b0, "R5", "refused channel makes no cycle", nwr - base, 0);
    load_ch(0, 'h60, 'hC0, 1'b0, 1'b1, 1'b1, 1, 0);
    chk(err_flag[0] == 1'b1 && ch_enabled[0] == 1'b0, "R5", "zero count refused",
        int'({err_flag[0], ch_enabled[0]}), 2);
    load_ch(0, 'h60, 'hC0, 1'b0, 1'b1, 1'b1, 3, 1);
    chk(err_flag[0] == 1'b0 && ch_enabled[0] == 1'b1, "R5", "legal reload clears error",
        int'({err_flag[0], ch_enabled[0]}), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    settle(3);
    t_reset();
    rst_n = 1'b1;
    settle(2);
    t_byte_increment();
    t_halfword_stall();
    t_priority();
    t_same_channel_drop();
    t_illegal_setup();
    settle(5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule